// File: doc/BRIEF.md
# Paired Float Compare to Condition Field

This block compares two IEEE-754 operands and records the outcome as a 4-bit value in one chosen field of a 32-bit condition register. The result is the updated register. It works in three formats. A scalar single-precision compare uses only the low 32 bits of each operand. A scalar double-precision compare uses all 64 bits. A paired compare treats each 64-bit operand as two independent single-precision lanes.

The caller gives the operands, a format code, a relation code, a field index and the present value of the condition register, and asserts `in_valid`. One clock later the block presents the register with the chosen field replaced. It also presents an invalid-operation flag, which rises only when a signaling NaN takes part in the compare. The compare itself is combinational. A small output-stage state machine with two states, OUT_IDLE and OUT_HELD, registers the result. The machine moves to OUT_HELD on any cycle with `in_valid` high and returns to OUT_IDLE on any cycle without it. `out_valid` is high exactly in OUT_HELD.

Top module: `fcmp_crfield`

## Requirements
- R1: Format code 0 selects a scalar single-precision compare of `op_a[31:0]` against `op_b[31:0]`. Bits 63:32 of either operand have no effect in this format.
- R2: Format code 1 selects a scalar double-precision compare over all 64 bits. Infinities order above and below every finite value of their sign.
- R3: Relation code 0 tests a > b, code 1 tests a < b and code 2 tests a == b. Code 3 never holds and writes field value 0.
- R4: In both scalar formats the written field is 4'b0100 when the relation holds and 4'b0000 otherwise.
- R5: Format code 2 selects the paired compare. The upper lane (bits 63:32) gives result h and the lower lane (bits 31:0) gives result l. The field is written as {h, l, h|l, h&l}, from bit 3 down to bit 0.
- R6: A NaN operand (all-ones exponent, nonzero fraction) makes its compare unordered, so the relation is false. The invalid flag rises only if a NaN in a compared lane or scalar is signaling, meaning the top fraction bit is 0. In paired mode each lane is tested on its own.
- R7: Positive and negative zero compare equal, and neither is greater than or less than the other.
- R8: Field index k occupies condition bits [4*(7-k)+3 : 4*(7-k)], so index 0 is bits 31:28. All other bits of `cr_out` equal `cr_in` as sampled with the request.
- R9: `out_valid` equals `in_valid` delayed by one clock. The result of a request appears on the clock edge after it is sampled.
- R10: On a cycle without `in_valid`, `cr_out` and `invalid` keep their values, whatever the other inputs do.
- R11: While reset is low, `out_valid`, `cr_out` and `invalid` are all zero.
- R12: Format code 3 is reserved. It writes field value 0 and keeps `invalid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| mode_sel | input | 2 | Format code: 0 single, 1 double, 2 paired, 3 reserved |
| rel_sel | input | 2 | Relation code: 0 greater, 1 less, 2 equal, 3 never |
| fld_idx | input | 3 | Target field index |
| cr_in | input | 32 | Present condition register |
| op_a | input | 64 | Left operand |
| op_b | input | 64 | Right operand |
| out_valid | output | 1 | Result valid, one cycle after the request |
| cr_out | output | 32 | Condition register with the chosen field replaced |
| invalid | output | 1 | Signaling-NaN invalid-operation flag |

## Verification
The assertions check the following on every cycle:
- the one-cycle timing of `out_valid`;
- that outputs hold while no request arrives;
- that the fields outside the target pass through unchanged;
- that a scalar field is either 0 or 4'b0100;
- that a paired field's OR and AND bits agree with its two lane bits;
- that the reserved format and the reserved relation write zero;
- that `invalid` stays low when no single-precision operand is a NaN.

Only the bench's scenarios show the numeric ordering itself. That covers signed zeros, infinities, quiet versus signaling NaNs, the lane order in paired mode, and that the upper operand bits are ignored in single mode. The bench checks these against its own real-valued model.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [1:0] {
        MODE_SP   = 2'd0,
        MODE_DP   = 2'd1,
        MODE_PAIR = 2'd2,
        MODE_RSV  = 2'd3
    } fcmp_mode_e;

    typedef enum logic [1:0] {
        REL_GT  = 2'd0,
        REL_LT  = 2'd1,
        REL_EQ  = 2'd2,
        REL_NONE = 2'd3
    } fcmp_rel_e;

    typedef enum logic {
        OUT_IDLE = 1'b0,
        OUT_HELD = 1'b1
    } fcmp_state_e;

    // Selects which ordered outcome the relation code asks for.
    function automatic logic rel_hit(fcmp_rel_e rel, logic gt, logic lt, logic eq);
        logic hit;
        unique case (rel)
            REL_GT:   hit = gt;
            REL_LT:   hit = lt;
            REL_EQ:   hit = eq;
            REL_NONE: hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/fcmp_lane_cmp.sv
module fcmp_lane_cmp #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    output logic                 gt,
    output logic                 lt,
    output logic                 eq,
    output logic                 sig_nan
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic             sgn_a, sgn_b;
    logic [EXP_W-1:0] exp_a, exp_b;
    logic [MAN_W-1:0] man_a, man_b;
    logic [W-2:0]     mag_a, mag_b;
    logic             nan_a, nan_b, unord;
    logic             both_zero, mag_gt, mag_eq;
    logic             o_gt, o_eq;

    assign sgn_a = a[W-1];
    assign sgn_b = b[W-1];
    assign exp_a = a[W-2 -: EXP_W];
    assign exp_b = b[W-2 -: EXP_W];
    assign man_a = a[MAN_W-1:0];
    assign man_b = b[MAN_W-1:0];
    assign mag_a = a[W-2:0];
    assign mag_b = b[W-2:0];

    assign nan_a = (&exp_a) && (|man_a);
    assign nan_b = (&exp_b) && (|man_b);
    assign unord = nan_a || nan_b;

    // A NaN with a clear top fraction bit is the signaling kind.
    assign sig_nan = (nan_a && !man_a[MAN_W-1]) || (nan_b && !man_b[MAN_W-1]);

    assign both_zero = (mag_a == '0) && (mag_b == '0);
    assign mag_gt    = mag_a > mag_b;
    assign mag_eq    = mag_a == mag_b;

    always_comb begin
        o_eq = both_zero || (mag_eq && (sgn_a == sgn_b));
        if (o_eq) begin
            o_gt = 1'b0;
        end else if (sgn_a != sgn_b) begin
            o_gt = !sgn_a;
        end else if (!sgn_a) begin
            o_gt = mag_gt;
        end else begin
            o_gt = !mag_gt;
        end
    end

    assign gt = !unord && o_gt;
    assign eq = !unord && o_eq;
    assign lt = !unord && !o_gt && !o_eq;

endmodule

// File: rtl/fcmp_cr_insert.sv
module fcmp_cr_insert #(
    parameter int CR_W  = 32,
    parameter int FLD_W = 4
) (
    input  logic [CR_W-1:0]                  cr_in,
    input  logic [$clog2(CR_W/FLD_W)-1:0]    idx,
    input  logic [FLD_W-1:0]                 fld,
    output logic [CR_W-1:0]                  cr_out
);
    localparam int NUM_F = CR_W / FLD_W;
    localparam int IDX_W = $clog2(NUM_F);

    // Field 0 sits at the most significant end of the register.
    for (genvar f = 0; f < NUM_F; f++) begin : g_field
        localparam logic [IDX_W-1:0] SEL = IDX_W'(NUM_F - 1 - f);
        assign cr_out[f*FLD_W +: FLD_W] = (idx == SEL) ? fld : cr_in[f*FLD_W +: FLD_W];
    end

endmodule

// File: rtl/fcmp_crfield.sv
module fcmp_crfield
    import fcmp_pkg::*;
#(
    parameter int CR_W   = 32,
    parameter int SP_EXP = 8,
    parameter int SP_MAN = 23,
    parameter int DP_EXP = 11,
    parameter int DP_MAN = 52
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [1:0]                      mode_sel,
    input  logic [1:0]                      rel_sel,
    input  logic [$clog2(CR_W/4)-1:0]       fld_idx,
    input  logic [CR_W-1:0]                 cr_in,
    input  logic [DP_EXP+DP_MAN:0]          op_a,
    input  logic [DP_EXP+DP_MAN:0]          op_b,
    output logic                            out_valid,
    output logic [CR_W-1:0]                 cr_out,
    output logic                            invalid
);
    localparam int FLD_W = 4;
    localparam int SP_W  = 1 + SP_EXP + SP_MAN;
    localparam int DP_W  = 1 + DP_EXP + DP_MAN;
    localparam int LANES = DP_W / SP_W;

    fcmp_mode_e mode;
    fcmp_rel_e  rel;
    assign mode = fcmp_mode_e'(mode_sel);
    assign rel  = fcmp_rel_e'(rel_sel);

    // Single-precision lanes: lane 0 is the low word, lane LANES-1 the high word.
    logic [LANES-1:0] ln_gt, ln_lt, ln_eq, ln_snan, ln_hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fcmp_lane_cmp #(
            .EXP_W (SP_EXP),
            .MAN_W (SP_MAN)
        ) u_sp (
            .a       (op_a[g*SP_W +: SP_W]),
            .b       (op_b[g*SP_W +: SP_W]),
            .gt      (ln_gt[g]),
            .lt      (ln_lt[g]),
            .eq      (ln_eq[g]),
            .sig_nan (ln_snan[g])
        );
        assign ln_hit[g] = rel_hit(rel, ln_gt[g], ln_lt[g], ln_eq[g]);
    end

    logic dp_gt, dp_lt, dp_eq, dp_snan, dp_hit;

    fcmp_lane_cmp #(
        .EXP_W (DP_EXP),
        .MAN_W (DP_MAN)
    ) u_dp (
        .a       (op_a),
        .b       (op_b),
        .gt      (dp_gt),
        .lt      (dp_lt),
        .eq      (dp_eq),
        .sig_nan (dp_snan)
    );
    assign dp_hit = rel_hit(rel, dp_gt, dp_lt, dp_eq);

    // Field value and invalid flag for the selected format.
    logic [FLD_W-1:0] fld_nxt;
    logic             inv_nxt;
    logic             hi_hit, lo_hit;

    assign hi_hit = ln_hit[LANES-1];
    assign lo_hit = ln_hit[0];

    always_comb begin
        unique case (mode)
            MODE_SP: begin
                fld_nxt = {1'b0, lo_hit, 2'b00};
                inv_nxt = ln_snan[0];
            end
            MODE_DP: begin
                fld_nxt = {1'b0, dp_hit, 2'b00};
                inv_nxt = dp_snan;
            end
            MODE_PAIR: begin
                fld_nxt = {hi_hit, lo_hit, hi_hit | lo_hit, hi_hit & lo_hit};
                inv_nxt = ln_snan[LANES-1] | ln_snan[0];
            end
            MODE_RSV: begin
                fld_nxt = '0;
                inv_nxt = 1'b0;
            end
        endcase
    end

    logic [CR_W-1:0] cr_nxt;

    fcmp_cr_insert #(
        .CR_W  (CR_W),
        .FLD_W (FLD_W)
    ) u_ins (
        .cr_in  (cr_in),
        .idx    (fld_idx),
        .fld    (fld_nxt),
        .cr_out (cr_nxt)
    );

    // Output stage state machine.
    fcmp_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            OUT_IDLE: state_d = in_valid ? OUT_HELD : OUT_IDLE;
            OUT_HELD: state_d = in_valid ? OUT_HELD : OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    logic [CR_W-1:0] cr_q;
    logic            inv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q  <= '0;
            inv_q <= 1'b0;
        end else if (in_valid) begin
            cr_q  <= cr_nxt;
            inv_q <= inv_nxt;
        end
    end

    assign out_valid = (state_q == OUT_HELD);
    assign cr_out    = cr_q;
    assign invalid   = inv_q;

endmodule

// File: rtl/fcmp_crfield_chk.sv
module fcmp_crfield_chk #(
    parameter int CR_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [1:0]                mode_sel,
    input logic [1:0]                rel_sel,
    input logic [$clog2(CR_W/4)-1:0] fld_idx,
    input logic [CR_W-1:0]           cr_in,
    input logic [63:0]               op_a,
    input logic [63:0]               op_b,
    input logic                      out_valid,
    input logic [CR_W-1:0]           cr_out,
    input logic                      invalid
);
    localparam int NUM_F = CR_W / 4;

    function automatic logic [CR_W-1:0] fmask(logic [$clog2(CR_W/4)-1:0] k);
        return {{(CR_W-4){1'b0}}, 4'hF} << (4 * (NUM_F - 1 - int'(k)));
    endfunction

    function automatic logic [3:0] fget(logic [CR_W-1:0] cr, logic [$clog2(CR_W/4)-1:0] k);
        return 4'(cr >> (4 * (NUM_F - 1 - int'(k))));
    endfunction

    function automatic logic sp_nan(logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
    endfunction

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(cr_out) && $stable(invalid)));

    // R8
    other_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (((cr_out ^ $past(cr_in)) & ~fmask($past(fld_idx))) == '0));

    // R4
    scalar_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode_sel == 2'd0 || mode_sel == 2'd1)) |=>
        (fget(cr_out, $past(fld_idx)) == 4'h0 || fget(cr_out, $past(fld_idx)) == 4'h4));

    // R5
    pair_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel == 2'd2) |=>
        (fget(cr_out, $past(fld_idx))[1] == (fget(cr_out, $past(fld_idx))[3] | fget(cr_out, $past(fld_idx))[2])
         && fget(cr_out, $past(fld_idx))[0] == (fget(cr_out, $past(fld_idx))[3] & fget(cr_out, $past(fld_idx))[2])));

    // R12
    reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel == 2'd3) |=> (fget(cr_out, $past(fld_idx)) == 4'h0 && !invalid));

    // R3
    never_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rel_sel == 2'd3) |=> (fget(cr_out, $past(fld_idx)) == 4'h0));

    // R6
    no_nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel == 2'd0 && !sp_nan(op_a[31:0]) && !sp_nan(op_b[31:0])) |=> !invalid);

endmodule

bind fcmp_crfield fcmp_crfield_chk #(.CR_W(CR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode_sel  (mode_sel),
    .rel_sel   (rel_sel),
    .fld_idx   (fld_idx),
    .cr_in     (cr_in),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .cr_out    (cr_out),
    .invalid   (invalid)
);

// File: tb/fcmp_crfield_bench.sv
`timescale 1ns/1ps
module fcmp_crfield_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode_sel = '0;
    logic [1:0]  rel_sel = '0;
    logic [2:0]  fld_idx = '0;
    logic [31:0] cr_in = '0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        out_valid;
    logic [31:0] cr_out;
    logic        invalid;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    fcmp_crfield u_fcmp_crfield (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_sel(mode_sel),
        .rel_sel(rel_sel), .fld_idx(fld_idx), .cr_in(cr_in), .op_a(op_a),
        .op_b(op_b), .out_valid(out_valid), .cr_out(cr_out), .invalid(invalid)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // ---- reference model on real numbers ----
    function automatic bit sp_isnan(logic [31:0] x);
        return x[30:23] == 8'hFF && x[22:0] != 0;
    endfunction
    function automatic bit sp_issnan(logic [31:0] x);
        return sp_isnan(x) && !x[22];
    endfunction
    function automatic real sp_val(logic [31:0] x);
        real v;
        if (x[30:23] == 8'hFF) v = 1.0e300;
        else if (x[30:23] == 0) v = real'(x[22:0]) * (2.0 ** (-149.0));
        else v = (1.0 + real'(x[22:0]) / 8388608.0) * (2.0 ** (real'(x[30:23]) - 127.0));
        return x[31] ? -v : v;
    endfunction
    function automatic bit dp_isnan(logic [63:0] x);
        return x[62:52] == 11'h7FF && x[51:0] != 0;
    endfunction
    function automatic bit dp_issnan(logic [63:0] x);
        return dp_isnan(x) && !x[51];
    endfunction
    function automatic bit rel_ref(logic [1:0] r, real a, real b);
        case (r)
            2'd0: return a > b;
            2'd1: return a < b;
            2'd2: return a == b;
            default: return 1'b0;
        endcase
    endfunction
    function automatic bit sp_hit(logic [1:0] r, logic [31:0] a, logic [31:0] b);
        if (sp_isnan(a) || sp_isnan(b)) return 1'b0;
        return rel_ref(r, sp_val(a), sp_val(b));
    endfunction

    task automatic model(input logic [1:0] m, input logic [1:0] r, input logic [63:0] a,
                         input logic [63:0] b, output logic [3:0] fld, output bit inv);
        bit h, l;
        case (m)
            2'd0: begin
                fld = {1'b0, sp_hit(r, a[31:0], b[31:0]), 2'b00};
                inv = sp_issnan(a[31:0]) || sp_issnan(b[31:0]);
            end
            2'd1: begin
                if (dp_isnan(a) || dp_isnan(b)) l = 0;
                else l = rel_ref(r, $bitstoreal(a), $bitstoreal(b));
                fld = {1'b0, l, 2'b00};
                inv = dp_issnan(a) || dp_issnan(b);
            end
            2'd2: begin
                h = sp_hit(r, a[63:32], b[63:32]);
                l = sp_hit(r, a[31:0], b[31:0]);
                fld = {h, l, h | l, h & l};
                inv = sp_issnan(a[63:32]) || sp_issnan(b[63:32]) ||
                      sp_issnan(a[31:0]) || sp_issnan(b[31:0]);
            end
            default: begin
                fld = 4'h0;
                inv = 1'b0;
            end
        endcase
    endtask

    // Drives one request at a falling edge and checks the registered result.
    task automatic apply(input logic [1:0] m, input logic [1:0] r, input logic [2:0] k,
                         input logic [31:0] cr, input logic [63:0] a, input logic [63:0] b,
                         input string tag);
        logic [3:0]  fld;
        bit          inv;
        logic [31:0] exp_cr;
        int          sh;
        model(m, r, a, b, fld, inv);
        sh = 4 * (7 - int'(k));
        exp_cr = (cr & ~(32'hF << sh)) | (32'(fld) << sh);
        mode_sel = m; rel_sel = r; fld_idx = k; cr_in = cr; op_a = a; op_b = b;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1, {tag, " R9 valid"}, 64'(out_valid), 64'd1);
        chk(cr_out === exp_cr, {tag, " cr"}, 64'(cr_out), 64'(exp_cr));
        chk(invalid === inv, {tag, " inv"}, 64'(invalid), 64'(inv));
    endtask

    function automatic logic [31:0] rnd_sp();
        logic [31:0] v;
        case ($urandom % 9)
            0: v = 32'h0000_0000;
            1: v = 32'h8000_0000;
            2: v = 32'h7F80_0000;
            3: v = 32'hFF80_0000;
            4: v = {$urandom % 2 == 0, 31'h7FC0_0001};
            5: v = 32'h7F80_0001 | ($urandom & 32'h003F_FFFF);
            6: v = 32'h3F80_0000 + (($urandom % 4) << 23);
            7: v = {$urandom % 2 == 0, 31'h3F80_0000};
            default: v = $urandom;
        endcase
        return v;
    endfunction

    function automatic logic [63:0] rnd_dp();
        logic [63:0] v;
        case ($urandom % 8)
            0: v = 64'h0;
            1: v = 64'h8000_0000_0000_0000;
            2: v = 64'h7FF0_0000_0000_0000;
            3: v = 64'hFFF0_0000_0000_0000;
            4: v = 64'h7FF8_0000_0000_0001;
            5: v = 64'h7FF0_0000_0000_0003;
            6: v = 64'h3FF0_0000_0000_0000 + (64'($urandom % 4) << 52);
            default: v = {$urandom, $urandom};
        endcase
        return v;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] cr_hold;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(out_valid === 1'b0, "R11 valid", 64'(out_valid), 0);
        chk(cr_out === 32'h0, "R11 cr", 64'(cr_out), 0);
        chk(invalid === 1'b0, "R11 inv", 64'(invalid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R8: single 1.0 < 2.0 at field 0 (bits 31:28)
        apply(2'd0, 2'd1, 3'd0, 32'hFFFF_FFFF, 64'h3F80_0000, 64'h4000_0000, "R4 R8 sp lt");
        chk(cr_out === 32'h4FFF_FFFF, "R8 field0", 64'(cr_out), 64'h4FFF_FFFF);
        // R1: upper bits differ, low words equal
        apply(2'd0, 2'd2, 3'd3, 32'h1234_5678, 64'hDEAD_BEEF_3F80_0000, 64'h0000_0001_3F80_0000, "R1 sp ignore hi");
        // R2: double 1.0 vs next value
        apply(2'd1, 2'd1, 3'd5, 32'h0, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0001, "R2 dp lt");
        apply(2'd1, 2'd0, 3'd5, 32'h0, 64'hFFF0_0000_0000_0000, 64'hC000_0000_0000_0000, "R2 dp -inf gt");
        // R7: signed zeros
        apply(2'd0, 2'd2, 3'd1, 32'h0, 64'h0000_0000, 64'h8000_0000, "R7 sp zero eq");
        apply(2'd1, 2'd0, 3'd1, 32'h0, 64'h8000_0000_0000_0000, 64'h0, "R7 dp zero gt");
        // R6: quiet vs signaling NaN
        apply(2'd0, 2'd2, 3'd2, 32'h0, 64'h7FC0_0000, 64'h7FC0_0000, "R6 qnan");
        apply(2'd0, 2'd1, 3'd2, 32'h0, 64'h7F80_0001, 64'h3F80_0000, "R6 snan");
        apply(2'd1, 2'd2, 3'd2, 32'h0, 64'h7FF0_0000_0000_0001, 64'h0, "R6 dp snan");
        // R5: paired, upper 3>1 true, lower 1>3 false -> 4'hA in field 7
        apply(2'd2, 2'd0, 3'd7, 32'h0, {32'h4040_0000, 32'h3F80_0000}, {32'h3F80_0000, 32'h4040_0000}, "R5 pair");
        chk(cr_out[3:0] === 4'hA, "R5 pair field", 64'(cr_out[3:0]), 64'hA);
        // R5 R6: lower-lane signaling NaN only, upper lane still holds
        apply(2'd2, 2'd2, 3'd4, 32'h0, {32'h3F80_0000, 32'hFF80_0002}, {32'h3F80_0000, 32'h0}, "R5 R6 pair snan");
        // R3: never relation
        apply(2'd0, 2'd3, 3'd6, 32'hFFFF_FFFF, 64'h3F80_0000, 64'h3F80_0000, "R3 none");
        // R12: reserved format
        apply(2'd3, 2'd2, 3'd6, 32'hFFFF_FFFF, 64'h7F80_0001, 64'h7F80_0001, "R12 rsv");

        // R9 R10: idle cycle with changed inputs
        cr_hold = cr_out;
        mode_sel = 2'd0; rel_sel = 2'd2; fld_idx = 3'd0; cr_in = 32'h0;
        op_a = 64'h7F80_0001; op_b = 64'h0;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R9 idle", 64'(out_valid), 0);
        chk(cr_out === cr_hold, "R10 hold cr", 64'(cr_out), 64'(cr_hold));
        chk(invalid === 1'b0, "R10 hold inv", 64'(invalid), 0);

        // Random mix over all formats (R1 R2 R5 R6 R7 R8)
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  m;
            logic [63:0] a, b;
            m = 2'($urandom % 4);
            if (m == 2'd1) begin
                a = rnd_dp();
                b = ($urandom % 4 == 0) ? a : rnd_dp();
            end else begin
                a = {rnd_sp(), rnd_sp()};
                b = ($urandom % 4 == 0) ? a : {rnd_sp(), rnd_sp()};
            end
            apply(m, 2'($urandom % 4), 3'($urandom % 8), $urandom, a, b, "rnd R1 R2 R5 R6");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule